// File: doc/BRIEF.md
# Mode-Banked Register File

This block stores the general-purpose registers of a processor core whose register view depends on the current privilege mode. Sixteen logical registers, each 32 bits wide, are visible at any time. Depending on the mode code in the low five bits of the status word, some high-numbered registers are served from private shadow copies instead of the shared set. The fast-interrupt mode has its own copies of registers 8 to 14. Four other exception modes each have their own copies of registers 13 and 14 only. Every other mode code sees only the shared registers.

The block also owns the current status word and one saved-status word for each of the five exception modes. A restore request copies the saved status of the current mode into the status word, and the register view switches to the restored mode. A restore request in a mode that has no saved status raises an error flag and leaves the status word as it was.

Register banking is a combinational index translation from (mode, logical index) to a physical slot. No data moves when the mode changes. Logical register 15, the program counter, has a dedicated write port. The general write port never changes it.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every shared register, every shadow copy, the program counter, the status word and all saved-status words read as zero, and `restore_err` is low.
- R2: The two read ports are combinational. A write through the general port with index 0..14 is committed at the clock edge and is visible on the read ports from the next cycle.
- R3: A read of index 15 returns the program counter. A general-port write with index 15 is ignored. `pc_wr_en` loads `pc_wr_data` into the program counter at the clock edge.
- R4: With mode code 0x11 in the status word, indices 8..14 access a private set of seven registers that is separate from every other mode.
- R5: Mode codes 0x12, 0x13, 0x17 and 0x1B each have a private pair of registers for indices 13 and 14. In these modes, indices 8..12 access the shared registers.
- R6: All other mode codes (for example 0x00, 0x10 and 0x1F) use the shared registers for indices 0..14. Indices 0..7 access the shared registers in every mode.
- R7: `stat_wr_en` loads `stat_wr_data` into the status word at the clock edge. The bank view follows the stored status word, so a mode change applies to accesses from the next cycle. Accesses in the same cycle as the change use the old mode.
- R8: `saved_rd_data` shows the saved status of the current exception mode, and `saved_wr_en` writes that same word. In a mode with no saved status, the read gives zero and the write is ignored.
- R9: A restore request in one of the five exception modes loads that mode's saved status, as it stood before the edge, into the status word. `restore_err` stays low.
- R10: A restore request in any other mode leaves the status word unchanged. `restore_err` goes high for exactly the following cycle and is never high otherwise.
- R11: When `restore_req` and `stat_wr_en` are both high in the same cycle, the restore wins and the status write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write logical index |
| wr_data | input | 32 | General write data |
| pc_wr_en | input | 1 | Program counter write enable |
| pc_wr_data | input | 32 | Program counter write data |
| pc_o | output | 32 | Current program counter |
| stat_wr_en | input | 1 | Status word write enable |
| stat_wr_data | input | 32 | Status word write data |
| stat_o | output | 32 | Current status word; bits 4:0 are the mode code |
| saved_wr_en | input | 1 | Saved-status write enable for the current mode |
| saved_wr_data | input | 32 | Saved-status write data |
| saved_rd_data | output | 32 | Saved status of the current mode, zero if none |
| restore_req | input | 1 | Request to restore status from the current mode's saved word |
| restore_err | output | 1 | High for one cycle after a restore request in a mode without saved status |

## Verification
Random traffic mixes writes and reads at all sixteen indices with mode switches through every banked code and several unbanked codes, including unlisted values such as 0x00 and 0x1F. A wrong slot mapping then shows up as a value written in one mode appearing in another. Directed sequences write the same index under user, fast-interrupt and IRQ modes one after another. This separates the seven-register bank from the two-register banks and from the shared set. Restore requests are issued both in exception modes, where the saved word chosen must belong to the old mode, and in unbanked modes, where the error flag must rise without a status change. A restore issued together with a status write exposes the wrong priority between the two.

// File: rtl/brf_pkg.sv
package brf_pkg;

  localparam int REG_IDX_W   = 4;
  localparam int NUM_LOGICAL = 1 << REG_IDX_W;
  localparam int PC_IDX      = NUM_LOGICAL - 1;
  localparam int MODE_W      = 5;

  // first logical index served by a private copy, per bank kind
  localparam int FIQ_FIRST   = 8;
  localparam int SMALL_FIRST = 13;

  localparam int COMMON_N    = NUM_LOGICAL - 1;
  localparam int FIQ_N       = PC_IDX - FIQ_FIRST;
  localparam int SMALL_N     = PC_IDX - SMALL_FIRST;
  localparam int SMALL_MODES = 4;

  localparam int FIQ_BASE    = COMMON_N;
  localparam int SMALL_BASE  = FIQ_BASE + FIQ_N;
  localparam int PHYS_N      = SMALL_BASE + SMALL_MODES * SMALL_N;
  localparam int PHYS_W      = $clog2(PHYS_N);

  localparam int SAVED_N     = SMALL_MODES + 1;
  localparam int SAVED_W     = $clog2(SAVED_N);

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

  typedef enum logic [2:0] {
    CLS_PLAIN = 3'd0,
    CLS_FIQ   = 3'd1,
    CLS_IRQ   = 3'd2,
    CLS_SVC   = 3'd3,
    CLS_ABT   = 3'd4,
    CLS_UND   = 3'd5
  } mode_cls_e;

  function automatic mode_cls_e classify_mode(input logic [MODE_W-1:0] m);
    mode_cls_e c;
    case (m)
      MODE_FIQ: c = CLS_FIQ;
      MODE_IRQ: c = CLS_IRQ;
      MODE_SVC: c = CLS_SVC;
      MODE_ABT: c = CLS_ABT;
      MODE_UND: c = CLS_UND;
      default:  c = CLS_PLAIN;
    endcase
    return c;
  endfunction

  function automatic logic has_saved(input mode_cls_e c);
    return c != CLS_PLAIN;
  endfunction

  // saved-status slot: fast interrupt first, then the four small-bank modes
  function automatic logic [SAVED_W-1:0] saved_slot(input mode_cls_e c);
    return SAVED_W'(int'(c) - 1);
  endfunction

  // logical index plus mode class -> physical storage slot
  function automatic logic [PHYS_W-1:0] phys_slot(input mode_cls_e c,
                                                  input logic [REG_IDX_W-1:0] idx);
    int s;
    int i;
    i = int'(idx);
    s = i;
    if (i < PC_IDX) begin
      if (c == CLS_FIQ && i >= FIQ_FIRST)
        s = FIQ_BASE + i - FIQ_FIRST;
      else if (c != CLS_PLAIN && c != CLS_FIQ && i >= SMALL_FIRST)
        s = SMALL_BASE + (int'(c) - int'(CLS_IRQ)) * SMALL_N + i - SMALL_FIRST;
    end
    return PHYS_W'(s);
  endfunction

endpackage

// File: rtl/brf_bank_map.sv
module brf_bank_map
  import brf_pkg::*;
(
  input  mode_cls_e              cls_i,
  input  logic [REG_IDX_W-1:0]   idx_i,
  output logic [PHYS_W-1:0]      slot_o,
  output logic                   is_pc_o
);

  always_comb begin
    slot_o  = phys_slot(cls_i, idx_i);
    is_pc_o = (idx_i == REG_IDX_W'(PC_IDX));
  end

endmodule

// File: rtl/brf_storage.sv
module brf_storage
  import brf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RD_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [PHYS_W-1:0]    wr_slot_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [PHYS_W-1:0]    rd_slot_i [RD_PORTS],
  output logic [DATA_W-1:0]    rd_data_o [RD_PORTS]
);

  logic [DATA_W-1:0] cell_q [PHYS_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < PHYS_N; e++) cell_q[e] <= '0;
    end else if (wr_en_i) begin
      for (int e = 0; e < PHYS_N; e++)
        if (wr_slot_i == PHYS_W'(e)) cell_q[e] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    always_comb begin
      rd_data_o[p] = '0;
      for (int e = 0; e < PHYS_N; e++)
        if (rd_slot_i[p] == PHYS_W'(e)) rd_data_o[p] = cell_q[e];
    end
  end

endmodule

// File: rtl/brf_status.sv
module brf_status
  import brf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stat_we_i,
  input  logic [DATA_W-1:0]  stat_wd_i,
  input  logic               saved_we_i,
  input  logic [DATA_W-1:0]  saved_wd_i,
  input  logic               restore_i,
  output logic [DATA_W-1:0]  stat_o,
  output mode_cls_e          cls_o,
  output logic [DATA_W-1:0]  saved_rd_o,
  output logic               err_o,
  output logic               restore_ok_o,
  output logic               restore_bad_o
);

  logic [DATA_W-1:0]  stat_q;
  logic [DATA_W-1:0]  saved_q [SAVED_N];
  logic               err_q;
  logic               cur_has;
  logic [SAVED_W-1:0] cur_slot;
  logic [DATA_W-1:0]  cur_saved;

  assign cls_o    = classify_mode(stat_q[MODE_W-1:0]);
  assign cur_has  = has_saved(cls_o);
  assign cur_slot = saved_slot(cls_o);

  always_comb begin
    cur_saved = '0;
    for (int k = 0; k < SAVED_N; k++)
      if (cur_has && cur_slot == SAVED_W'(k)) cur_saved = saved_q[k];
  end

  assign restore_ok_o  = restore_i && cur_has;
  assign restore_bad_o = restore_i && !cur_has;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= restore_bad_o;
      if (restore_ok_o)
        stat_q <= cur_saved;
      else if (!restore_i && stat_we_i)
        stat_q <= stat_wd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SAVED_N; k++) saved_q[k] <= '0;
    end else if (saved_we_i && cur_has) begin
      for (int k = 0; k < SAVED_N; k++)
        if (cur_slot == SAVED_W'(k)) saved_q[k] <= saved_wd_i;
    end
  end

  assign stat_o     = stat_q;
  assign saved_rd_o = cur_saved;
  assign err_o      = err_q;

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0]     rd_a_data,
  input  logic [REG_IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0]     rd_b_data,
  input  logic                  wr_en,
  input  logic [REG_IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  pc_wr_en,
  input  logic [DATA_W-1:0]     pc_wr_data,
  output logic [DATA_W-1:0]     pc_o,
  input  logic                  stat_wr_en,
  input  logic [DATA_W-1:0]     stat_wr_data,
  output logic [DATA_W-1:0]     stat_o,
  input  logic                  saved_wr_en,
  input  logic [DATA_W-1:0]     saved_wr_data,
  output logic [DATA_W-1:0]     saved_rd_data,
  input  logic                  restore_req,
  output logic                  restore_err
);

  localparam int RD_PORTS  = 2;
  localparam int MAP_PORTS = RD_PORTS + 1;
  localparam int WR_MAP    = RD_PORTS;

  mode_cls_e            cur_cls;
  logic [REG_IDX_W-1:0] map_idx  [MAP_PORTS];
  logic [PHYS_W-1:0]    map_slot [MAP_PORTS];
  logic                 map_pc   [MAP_PORTS];
  logic [PHYS_W-1:0]    rd_slot  [RD_PORTS];
  logic [DATA_W-1:0]    rd_store [RD_PORTS];
  logic [DATA_W-1:0]    rd_out   [RD_PORTS];
  logic [DATA_W-1:0]    pc_q;

  // named events for the checker
  logic ev_wr_accept;
  logic ev_restore_ok;
  logic ev_restore_bad;

  assign map_idx[0]      = rd_a_idx;
  assign map_idx[1]      = rd_b_idx;
  assign map_idx[WR_MAP] = wr_idx;

  for (genvar p = 0; p < MAP_PORTS; p++) begin : g_map
    brf_bank_map i_map (
      .cls_i   (cur_cls),
      .idx_i   (map_idx[p]),
      .slot_o  (map_slot[p]),
      .is_pc_o (map_pc[p])
    );
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rdsel
    assign rd_slot[p] = map_slot[p];
    assign rd_out[p]  = map_pc[p] ? pc_q : rd_store[p];
  end

  assign ev_wr_accept = wr_en && !map_pc[WR_MAP];

  brf_storage #(
    .DATA_W   (DATA_W),
    .RD_PORTS (RD_PORTS)
  ) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (ev_wr_accept),
    .wr_slot_i (map_slot[WR_MAP]),
    .wr_data_i (wr_data),
    .rd_slot_i (rd_slot),
    .rd_data_o (rd_store)
  );

  brf_status #(
    .DATA_W (DATA_W)
  ) i_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .stat_we_i     (stat_wr_en),
    .stat_wd_i     (stat_wr_data),
    .saved_we_i    (saved_wr_en),
    .saved_wd_i    (saved_wr_data),
    .restore_i     (restore_req),
    .stat_o        (stat_o),
    .cls_o         (cur_cls),
    .saved_rd_o    (saved_rd_data),
    .err_o         (restore_err),
    .restore_ok_o  (ev_restore_ok),
    .restore_bad_o (ev_restore_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= '0;
    else if (pc_wr_en) pc_q <= pc_wr_data;
  end

  assign pc_o      = pc_q;
  assign rd_a_data = rd_out[0];
  assign rd_b_data = rd_out[1];

endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              pc_wr_en,
  input logic [DATA_W-1:0] pc_wr_data,
  input logic [DATA_W-1:0] pc_o,
  input logic              stat_wr_en,
  input logic [DATA_W-1:0] stat_wr_data,
  input logic [DATA_W-1:0] stat_o,
  input logic [DATA_W-1:0] saved_rd_data,
  input logic              restore_req,
  input logic              restore_err,
  input logic              ev_restore_ok,
  input logic              ev_restore_bad
);

  assert_wr_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != 4'hF && !restore_req && !stat_wr_en) |=>
      (rd_a_idx != $past(wr_idx)) || (rd_a_data == $past(wr_data)));

  assert_pc_gen_wr_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'hF && !pc_wr_en) |=> $stable(pc_o));

  assert_pc_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_en |=> (pc_o == $past(pc_wr_data)));

  assert_low_common_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && stat_wr_en && !restore_req && rd_a_idx < 4'd8) |=>
      (rd_a_idx != $past(rd_a_idx)) || $stable(rd_a_data));

  assert_stat_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_en && !restore_req) |=> (stat_o == $past(stat_wr_data)));

  assert_restore_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_restore_ok |=> (stat_o == $past(saved_rd_data)) && !restore_err);

  assert_restore_bad_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_restore_bad |=> restore_err && $stable(stat_o));

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restore_err |-> $past(restore_req));

  assert_restore_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && stat_wr_en && ev_restore_bad) |=> $stable(stat_o));

endmodule

bind banked_regfile brf_checker #(.DATA_W(DATA_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rd_a_idx       (rd_a_idx),
  .rd_a_data      (rd_a_data),
  .wr_en          (wr_en),
  .wr_idx         (wr_idx),
  .wr_data        (wr_data),
  .pc_wr_en       (pc_wr_en),
  .pc_wr_data     (pc_wr_data),
  .pc_o           (pc_o),
  .stat_wr_en     (stat_wr_en),
  .stat_wr_data   (stat_wr_data),
  .stat_o         (stat_o),
  .saved_rd_data  (saved_rd_data),
  .restore_req    (restore_req),
  .restore_err    (restore_err),
  .ev_restore_ok  (ev_restore_ok),
  .ev_restore_bad (ev_restore_bad)
);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, pc_wr_en, stat_wr_en, saved_wr_en, restore_req;
  logic [31:0] pc_wr_data, pc_o, stat_wr_data, stat_o, saved_wr_data, saved_rd_data;
  logic        restore_err;

  always #4 clk = ~clk;

  banked_regfile i_banked_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .pc_o(pc_o),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .stat_o(stat_o),
    .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data), .saved_rd_data(saved_rd_data),
    .restore_req(restore_req), .restore_err(restore_err)
  );

  int checks = 0;
  int errors = 0;

  // reference state
  logic [31:0] m_com [15];
  logic [31:0] m_fiq [7];
  logic [31:0] m_sm  [8];
  logic [31:0] m_sav [5];
  logic [31:0] m_pc, m_stat;
  logic        m_err;
  logic        prev_restore, prev_stat_we;
  int          prev_cls;

  function automatic int bcls(input logic [4:0] m);
    case (m)
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] mread(input int idx);
    int c;
    c = bcls(m_stat[4:0]);
    if (idx == 15) return m_pc;
    if (c == 1 && idx >= 8) return m_fiq[idx-8];
    if (c >= 2 && idx >= 13) return m_sm[(c-2)*2 + idx - 13];
    return m_com[idx];
  endfunction

  function automatic string rtag(input int idx);
    int c;
    c = bcls(m_stat[4:0]);
    if (idx == 15) return "R3";
    if (c == 1 && idx >= 8) return "R4";
    if (c >= 2 && idx >= 8) return "R5";
    if (idx < 8 || c == 0) return "R6";
    return "R2";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic drv_clear();
    wr_en = 0; wr_idx = 0; wr_data = 0;
    pc_wr_en = 0; pc_wr_data = 0;
    stat_wr_en = 0; stat_wr_data = 0;
    saved_wr_en = 0; saved_wr_data = 0;
    restore_req = 0;
  endtask

  // called just after a falling edge with inputs driven
  task automatic tick();
    int c;
    logic [31:0] rest_val;
    string stag;
    #1;
    if (prev_restore && prev_stat_we) stag = "R11";
    else if (prev_restore)            stag = (prev_cls != 0) ? "R9" : "R10";
    else                              stag = "R7";
    chk(rtag(int'(rd_a_idx)), rd_a_data, mread(int'(rd_a_idx)));
    chk(rtag(int'(rd_b_idx)), rd_b_data, mread(int'(rd_b_idx)));
    chk("R3", pc_o, m_pc);
    chk(stag, stat_o, m_stat);
    c = bcls(m_stat[4:0]);
    chk("R8", saved_rd_data, (c == 0) ? 32'h0 : m_sav[c-1]);
    chk("R10", {31'b0, restore_err}, {31'b0, m_err});
    // next state
    rest_val = (c == 0) ? 32'h0 : m_sav[c-1];
    if (wr_en && wr_idx != 4'hF) begin
      if (c == 1 && wr_idx >= 8)       m_fiq[int'(wr_idx)-8] = wr_data;
      else if (c >= 2 && wr_idx >= 13) m_sm[(c-2)*2 + int'(wr_idx) - 13] = wr_data;
      else                             m_com[int'(wr_idx)] = wr_data;
    end
    if (pc_wr_en) m_pc = pc_wr_data;
    if (saved_wr_en && c != 0) m_sav[c-1] = saved_wr_data;
    m_err = 1'b0;
    if (restore_req) begin
      if (c != 0) m_stat = rest_val;
      else        m_err  = 1'b1;
    end else if (stat_wr_en) begin
      m_stat = stat_wr_data;
    end
    prev_restore = restore_req;
    prev_stat_we = stat_wr_en;
    prev_cls     = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_stat(input logic [31:0] v);
    drv_clear(); stat_wr_en = 1; stat_wr_data = v; tick();
  endtask

  task automatic do_wr(input logic [3:0] idx, input logic [31:0] v);
    drv_clear(); wr_en = 1; wr_idx = idx; wr_data = v; tick();
  endtask

  task automatic look(input logic [3:0] a, input logic [3:0] b);
    drv_clear(); rd_a_idx = a; rd_b_idx = b; tick();
  endtask

  function automatic logic [4:0] pick_mode(input int k);
    case (k % 8)
      0: return 5'h10;
      1: return 5'h11;
      2: return 5'h12;
      3: return 5'h13;
      4: return 5'h17;
      5: return 5'h1B;
      6: return 5'h1F;
      default: return 5'h00;
    endcase
  endfunction

  bit done = 0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2: watchdog expired, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h0000_5EED);
    for (int i = 0; i < 15; i++) m_com[i] = 0;
    for (int i = 0; i < 7; i++)  m_fiq[i] = 0;
    for (int i = 0; i < 8; i++)  m_sm[i] = 0;
    for (int i = 0; i < 5; i++)  m_sav[i] = 0;
    m_pc = 0; m_stat = 0; m_err = 0;
    prev_restore = 0; prev_stat_we = 0; prev_cls = 0;
    drv_clear();
    rd_a_idx = 0; rd_b_idx = 0;
    repeat (3) @(negedge clk);
    // R1: reset state seen through the ports
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i);
      #1 chk("R1", rd_a_data, 32'h0);
    end
    chk("R1", stat_o, 32'h0);
    chk("R1", saved_rd_data, 32'h0);
    chk("R1", pc_o, 32'h0);
    chk("R1", {31'b0, restore_err}, 32'h0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: shadow copies start at zero
    do_stat(32'h0000_0011); look(4'd8, 4'd14);
    do_stat(32'h0000_0013); look(4'd13, 4'd14);

    // R4 / R5 / R6: same indices under several modes
    do_stat(32'h0000_0010);
    do_wr(4'd8, 32'hAAAA_0008); do_wr(4'd13, 32'hAAAA_000D); do_wr(4'd3, 32'hAAAA_0003);
    do_stat(32'h0000_0011);
    look(4'd8, 4'd13);
    do_wr(4'd8, 32'hF1F1_0008); do_wr(4'd13, 32'hF1F1_000D);
    look(4'd8, 4'd3);
    do_stat(32'h0000_0012);
    look(4'd8, 4'd13);
    do_wr(4'd14, 32'h1212_000E);
    do_stat(32'h0000_001F);
    look(4'd14, 4'd8);

    // R3: general write to index 15 ignored, pc port works
    do_wr(4'hF, 32'hDEAD_BEEF); look(4'hF, 4'hF);
    drv_clear(); pc_wr_en = 1; pc_wr_data = 32'h0200_0000; tick();
    look(4'hF, 4'd0);

    // R8 / R9: saved status written in fast interrupt, restore to supervisor
    do_stat(32'h0000_0011);
    drv_clear(); saved_wr_en = 1; saved_wr_data = 32'h8000_0013; tick();
    drv_clear(); restore_req = 1; rd_a_idx = 4'd13; tick();
    look(4'd13, 4'd8);

    // R8: saved write in user mode ignored; R10: restore error
    do_stat(32'h0000_0010);
    drv_clear(); saved_wr_en = 1; saved_wr_data = 32'h1234_5678; tick();
    drv_clear(); restore_req = 1; tick();
    look(4'd0, 4'd1);

    // R11: restore and status write together
    drv_clear(); restore_req = 1; stat_wr_en = 1; stat_wr_data = 32'h0000_0011; tick();
    do_stat(32'h0000_0017);
    drv_clear(); saved_wr_en = 1; saved_wr_data = 32'h0000_001B; tick();
    drv_clear(); restore_req = 1; stat_wr_en = 1; stat_wr_data = 32'h0000_0010; tick();
    look(4'd13, 4'd14);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      drv_clear();
      rd_a_idx = 4'($urandom_range(0, 15));
      rd_b_idx = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1) begin
        wr_en = 1; wr_idx = 4'($urandom_range(0, 15)); wr_data = $urandom;
      end
      if ($urandom_range(0, 9) == 0) begin
        pc_wr_en = 1; pc_wr_data = $urandom;
      end
      if ($urandom_range(0, 6) == 0) begin
        stat_wr_en = 1;
        stat_wr_data = {$urandom_range(0, 255) << 5} | 32'(pick_mode(int'($urandom_range(0, 7))));
      end
      if ($urandom_range(0, 4) == 0) begin
        saved_wr_en = 1;
        saved_wr_data = {24'h0, 3'($urandom_range(0, 7)), pick_mode(int'($urandom_range(0, 7)))};
      end
      if ($urandom_range(0, 11) == 0) restore_req = 1;
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule